// File: doc/BRIEF.md
# Bidirectional Latched Serial-to-Parallel Driver

This block turns a serial bit stream into a wide set of parallel channel controls. Bits arrive on a serial data input and move through a chain of stages, one stage for each falling edge of a shift clock. A direction input decides which end of the chain takes in new data and which end feeds the cascade output, so several blocks can be daisy-chained in either orientation. The direction can be changed while the block runs.

A bank of level-sensitive holding stages sits between the chain and the channel outputs. While the capture input is high the bank follows the chain. While it is low the bank keeps its contents and the chain can be refilled without disturbing the outputs. A drive-enable input gates the channels. When drive is enabled, each channel is the inverse of its held bit, so a held 1 pulls the channel low (on). When drive is disabled, every channel is at the high (off) level.

The model is synchronous to a fast system clock. The shift clock is sampled on that clock, and a falling edge is recognised as a high sample followed by a low one.

Top module: `bidir_sipo_driver`

## Requirements
- R1: While reset is asserted and after its release, all chain stages and all holding stages are 0. After reset the cascade output is 0 and every channel is 1 (off), whatever the level of the drive-enable input.
- R2: The chain advances by exactly one stage on the system clock edge where the shift clock is sampled low after having been sampled high on the previous edge. It does not change on any other edge.
- R3: With the direction input at 1, a step loads the serial input into stage 1 (bit 0 of the channel vector) and moves each stage n into stage n+1. The cascade output shows the last stage (bit CHANNELS-1).
- R4: With the direction input at 0, a step loads the serial input into the last stage (bit CHANNELS-1) and moves each stage n into stage n-1. The cascade output shows stage 1 (bit 0).
- R5: The cascade output follows the direction input with no clock delay: it always shows the final stage of the currently selected direction.
- R6: The capture and drive-enable inputs have no effect on the chain. Stepping proceeds identically whatever their levels.
- R7: On each system clock edge where the capture input is 1, the holding bank takes the chain contents from before that edge. Where it is 0, the bank keeps its value.
- R8: While the drive-enable input is 0, every channel output is 1.
- R9: While the drive-enable input is 1, each channel output is the inverse of its holding bit: a held 1 gives 0 (on) and a held 0 gives 1 (off).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the shift clock is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Shift clock; its falling edge steps the chain |
| sdata_i | input | 1 | Serial data in |
| dir_i | input | 1 | Shift direction: 1 toward the high stage, 0 toward the low stage |
| le_i | input | 1 | Capture enable for the holding bank (transparent while 1) |
| oe_i | input | 1 | Drive enable for the channel outputs |
| chan_o | output | CHANNELS | Channel outputs, active low, bit 0 is stage 1 |
| cascade_o | output | 1 | Serial cascade output from the final stage |

## Verification
The bench builds the block with its default of 64 channels. This lets a single pattern travel the full length of the chain and show up at the cascade output after exactly 64 steps in each direction. It also lets the end-of-chain behaviour at stage 1 and stage 64 be checked against direction reversals made partway through a fill. A queue-based model steps on every system clock and is compared against all channels and the cascade output. Meanwhile, the capture and drive-enable inputs are toggled independently of the shift clock, so any leak of those inputs into the chain shows up as a mismatch.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
   typedef enum logic {
      DIR_TOWARD_LOW  = 1'b0,
      DIR_TOWARD_HIGH = 1'b1
   } shift_dir_e;

   localparam int unsigned MIN_CHANNELS = 2;
endpackage

// File: rtl/bsd_fall_detect.sv
module bsd_fall_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   output logic step_o
);
   logic sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_i;
   end

   assign step_o = sclk_q & ~sclk_i;

   assert_step_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |-> ($past(sclk_i) && !sclk_i));
endmodule

// File: rtl/bsd_shift_chain.sv
module bsd_shift_chain
   import bsd_pkg::*;
#(
   parameter int unsigned CHANNELS = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step_i,
   input  logic                dir_i,
   input  logic                sdata_i,
   output logic [CHANNELS-1:0] stages_o,
   output logic                cascade_o
);
   localparam int unsigned LAST = CHANNELS - 1;

   logic [CHANNELS-1:0] q;
   logic [CHANNELS-1:0] nxt;

   generate
      if (CHANNELS < MIN_CHANNELS) begin : g_bad
         $error("bsd_shift_chain: CHANNELS below minimum");
      end
      for (genvar i = 0; i < CHANNELS; i++) begin : g_stage
         logic from_low;
         logic from_high;
         if (i == 0) begin : g_first
            assign from_low = sdata_i;
         end else begin : g_mid_lo
            assign from_low = q[i-1];
         end
         if (i == LAST) begin : g_last
            assign from_high = sdata_i;
         end else begin : g_mid_hi
            assign from_high = q[i+1];
         end
         assign nxt[i] = (dir_i == DIR_TOWARD_HIGH) ? from_low : from_high;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (step_i) q <= nxt;
   end

   assign stages_o  = q;
   assign cascade_o = (dir_i == DIR_TOWARD_HIGH) ? q[LAST] : q[0];

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(q));
   assert_step_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && dir_i) |=> (q[0] == $past(sdata_i)) && (q[LAST:1] == $past(q[LAST-1:0])));
   assert_step_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !dir_i) |=> (q[LAST] == $past(sdata_i)) && (q[LAST-1:0] == $past(q[LAST:1])));
endmodule

// File: rtl/bsd_hold_bank.sv
module bsd_hold_bank #(
   parameter int unsigned CHANNELS = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                le_i,
   input  logic [CHANNELS-1:0] d_i,
   output logic [CHANNELS-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (le_i) q_o <= d_i;
   end

   assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      le_i |=> (q_o == $past(d_i)));
   assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !le_i |=> $stable(q_o));
endmodule

// File: rtl/bsd_out_stage.sv
module bsd_out_stage #(
   parameter int unsigned CHANNELS  = 64,
   parameter bit          OFF_LEVEL = 1'b1
) (
   input  logic                en_i,
   input  logic [CHANNELS-1:0] held_i,
   output logic [CHANNELS-1:0] chan_o
);
   generate
      for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
         assign chan_o[c] = en_i ? (held_i[c] ^ OFF_LEVEL) : OFF_LEVEL;
      end
   endgenerate
endmodule

// File: rtl/bidir_sipo_driver.sv
module bidir_sipo_driver #(
   parameter int unsigned CHANNELS = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sclk_i,
   input  logic                sdata_i,
   input  logic                dir_i,
   input  logic                le_i,
   input  logic                oe_i,
   output logic [CHANNELS-1:0] chan_o,
   output logic                cascade_o
);
   logic                step_w;
   logic [CHANNELS-1:0] stages_w;
   logic [CHANNELS-1:0] held_w;

   bsd_fall_detect u_fall (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_i (sclk_i),
      .step_o (step_w)
   );

   bsd_shift_chain #(.CHANNELS(CHANNELS)) u_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (step_w),
      .dir_i     (dir_i),
      .sdata_i   (sdata_i),
      .stages_o  (stages_w),
      .cascade_o (cascade_o)
   );

   bsd_hold_bank #(.CHANNELS(CHANNELS)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .le_i  (le_i),
      .d_i   (stages_w),
      .q_o   (held_w)
   );

   bsd_out_stage #(.CHANNELS(CHANNELS), .OFF_LEVEL(1'b1)) u_out (
      .en_i   (oe_i),
      .held_i (held_w),
      .chan_o (chan_o)
   );

   assert_off_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_i |-> (&chan_o));
   assert_inverse_when_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      oe_i |-> (&(chan_o ^ held_w)));
   assert_cascade_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cascade_o == (dir_i ? stages_w[CHANNELS-1] : stages_w[0]));
endmodule

// File: tb/bidir_sipo_driver_tb.sv
`timescale 1ns/1ps
module bidir_sipo_driver_tb;
   localparam int CLK_P = 10;
   localparam int CH    = 64;
   localparam int WDOG  = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sclk = 1'b0, sdata = 1'b0, dir = 1'b1, le = 1'b0, oe = 1'b0;
   logic [CH-1:0] chan;
   logic          casc;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit cmp_en = 1'b0;

   bit mq[$];
   bit ml[CH];
   bit mprev = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   bidir_sipo_driver #(.CHANNELS(CH)) u_dut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata),
      .dir_i(dir), .le_i(le), .oe_i(oe), .chan_o(chan), .cascade_o(casc)
   );

   task automatic check(input string req, input logic [CH-1:0] act, input logic [CH-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   function automatic logic [CH-1:0] exp_chan();
      logic [CH-1:0] v;
      for (int i = 0; i < CH; i++) v[i] = oe ? ~ml[i] : 1'b1;
      return v;
   endfunction

   function automatic logic exp_casc();
      return dir ? mq[CH-1] : mq[0];
   endfunction

   // reference model: queue index 0 is stage 1
   initial for (int i = 0; i < CH; i++) mq.push_back(1'b0);

   always @(posedge clk) begin
      cyc++;
      if (cyc > WDOG) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WDOG);
         summary();
      end
      if (!rst_n) begin
         for (int i = 0; i < CH; i++) begin mq[i] = 1'b0; ml[i] = 1'b0; end
         mprev = 1'b0;
      end else begin
         if (le) for (int i = 0; i < CH; i++) ml[i] = mq[i];
         if (mprev && !sclk) begin
            if (dir) begin mq.push_front(sdata); void'(mq.pop_back()); end
            else     begin mq.push_back(sdata);  void'(mq.pop_front()); end
         end
         mprev = sclk;
      end
   end

   // per-cycle comparison, away from the clock edge
   always begin
      @(posedge clk);
      #(CLK_P/4);
      if (cmp_en) begin
         check("R2 R3 R4 R6 R7 R8 R9 channels", chan, exp_chan());
         check("R3 R4 R5 cascade", {{(CH-1){1'b0}}, casc}, {{(CH-1){1'b0}}, exp_casc()});
      end
   end

   task automatic fall(input logic d);
      @(negedge clk); sclk = 1'b1; sdata = d;
      @(negedge clk); sclk = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      logic [CH-1:0] snap;
      repeat (3) @(negedge clk);
      check("R1 channels in reset", chan, '1);
      check("R1 cascade in reset", {{(CH-1){1'b0}}, casc}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      oe = 1'b1;
      @(negedge clk);
      check("R1 channels after reset", chan, '1);
      cmp_en = 1'b1;

      // R3: fill with ones toward the high stage, capture transparent
      dir = 1'b1; le = 1'b1;
      for (int i = 0; i < CH; i++) fall(1'b1);
      @(negedge clk);
      check("R3 R9 full ones all on", chan, '0);
      check("R3 cascade last stage", {{(CH-1){1'b0}}, casc}, {{(CH-1){1'b0}}, 1'b1});
      oe = 1'b0;
      @(negedge clk);
      check("R8 drive disabled all off", chan, '1);
      oe = 1'b1;

      // R6: random data while capture and drive toggle
      for (int i = 0; i < 70; i++) begin
         le = i[0]; oe = i[1];
         fall(1'($urandom));
      end

      // R4: opposite direction
      dir = 1'b0; le = 1'b1; oe = 1'b1;
      for (int i = 0; i < 40; i++) fall(1'($urandom));

      // R5: reversal mid-fill, cascade follows immediately
      dir = 1'b1;
      @(negedge clk);
      fall(1'b0);
      dir = 1'b0;
      fall(1'b1);

      // R7: hold while chain keeps stepping
      @(negedge clk); @(negedge clk);
      le = 1'b0;
      @(negedge clk);
      snap = chan;
      for (int i = 0; i < 30; i++) fall(~sdata);
      check("R7 holding bank kept", chan, snap);
      le = 1'b1;
      @(negedge clk); @(negedge clk);

      // R2: shift clock held high, no step
      @(negedge clk); sclk = 1'b1;
      repeat (5) @(negedge clk);
      sclk = 1'b0;
      repeat (3) @(negedge clk);

      // drain with zeros toward the low stage
      dir = 1'b0;
      for (int i = 0; i < CH; i++) fall(1'b0);
      @(negedge clk);
      check("R4 R9 drained all off", chan, '1);

      cmp_en = 1'b0;
      summary();
   end
endmodule